// File: doc/BRIEF.md
# Pulsed Byte Program Sequencer

This block is a host-side controller that writes one byte at a time into an external non-volatile memory. It does not rely on a single long write. Instead it runs a closed loop: it arms the memory, supplies the data byte to start a program pulse of fixed length, then switches the memory into a margin-check mode and reads the byte back. When the read-back byte equals the intended byte, that location is finished. When it differs, another pulse is applied. The number of pulses per byte is capped. If the cap is reached without a match, the byte is reported as failed.

A request is a single-cycle `req_valid` carrying an address and a data byte. It is taken only while the block is idle. The block then runs the memory interface by itself, one command per clock, and keeps the high-voltage supply enable asserted from the first command to the final compare. At the end it gives a one-cycle `done`, a sticky `fail` flag and the number of pulses the byte needed. The pulse length is set in microseconds and converted to clock cycles from a clock-frequency parameter.

Top module: `byte_burn_ctrl`

## Requirements
- R1: After reset `busy`, `done`, `fail`, `hv_en`, `mem_we` and `mem_rd` are 0 and `pulses_used` is 0.
- R2: A request (`req_valid` high) is accepted only when `busy` is 0. `busy` rises in the cycle after acceptance and stays high until the byte finishes. `req_valid` seen while `busy` is high has no effect: the address being worked on does not change and no extra result is produced.
- R3: Each pulse is a command write of 8'h40 (arm) to the request address, followed in the next cycle by a write of the request data byte. The following margin command is written exactly PULSE_CYC = (CLK_HZ/1_000_000)*PULSE_US cycles after the data write.
- R4: Every pulse is followed by a verify step: a command write of 8'hC0 (margin check), then a read strobe in the next cycle. The byte returned on `mem_rdata` in the cycle after the strobe is compared with the request data.
- R5: A matching compare ends the byte. `done` is high for one cycle, `fail` is 0, `pulses_used` holds the number of pulses applied, and the block returns to idle.
- R6: At most MAX_PULSES pulses are applied to a byte. If the compare after pulse MAX_PULSES still differs, `done` is high for one cycle, `fail` is set and `pulses_used` equals MAX_PULSES.
- R7: `fail` is sticky. It stays high until the next accepted request, which clears it.
- R8: `hv_en` is high during the whole arm/pulse/verify loop, including between retries, and is 0 whenever the block is idle.
- R9: `mem_addr` drives the accepted request address on every command write and read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_addr | input | ADDR_W | Target byte address |
| req_data | input | DATA_W | Byte to program |
| busy | output | 1 | A byte is in progress |
| done | output | 1 | One-cycle pulse when a byte finishes, pass or fail |
| fail | output | 1 | Sticky failure flag for the last byte |
| pulses_used | output | CNT_W | Pulses applied to the last finished byte |
| hv_en | output | 1 | High-voltage programming supply enable |
| mem_we | output | 1 | Memory command/data write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory command or data byte |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_rd` |

## Verification
The bench instantiates the block with CLK_HZ = 1,000,000 and PULSE_US = 5. This makes each pulse 5 cycles long instead of several hundred, so the exact pulse-to-margin spacing can be measured on every retry. MAX_PULSES stays at 25. Because pulses are short, a byte that needs all 25 pulses, and a byte that never verifies, both finish within a few hundred cycles. The bench therefore reaches the exact cap boundary as well as the failure path. The memory model returns the true byte only after the margin command, so a design that skips the margin step miscompares.

// File: rtl/byte_burn_pkg.sv
// Package: shared state encoding and memory command codes for the byte
// program sequencer. Assumes an 8-bit memory command bus.
package byte_burn_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_ARM    = 3'd1,
        S_LOAD   = 3'd2,
        S_BURN   = 3'd3,
        S_MARGIN = 3'd4,
        S_READ   = 3'd5,
        S_CMP    = 3'd6
    } burn_state_t;

    // Command byte that arms the memory for a data write
    localparam logic [7:0] OP_ARM   = 8'h40;
    // Command byte that selects the margin read-back condition
    localparam logic [7:0] OP_CHECK = 8'hC0;

    // Converts a pulse length in microseconds into clock cycles
    function automatic int unsigned pulse_cycles(input int unsigned clk_hz,
                                                 input int unsigned pulse_us);
        return (clk_hz / 1_000_000) * pulse_us;
    endfunction

endpackage

// File: rtl/byte_burn_timer.sv
// Module: pulse-duration down counter. It is loaded in the data-write cycle
// with LOAD_VAL and counts down while `run` is high. `expired` is high once
// the count reaches zero. Assumes LOAD_VAL fits in CNT_W bits.
module byte_burn_timer #(
    parameter int unsigned CNT_W    = 9,
    parameter int unsigned LOAD_VAL = 498
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);

    logic [CNT_W-1:0] cnt_q;

    // Load on pulse start, count down while the pulse is running
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(LOAD_VAL);
        end else if (run && cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Pulse time is over when the count is zero
    always_comb begin
        expired = (cnt_q == '0);
    end

endmodule

// File: rtl/byte_burn_retry.sv
// Module: per-byte pulse counter. It is cleared when a request is accepted
// and bumped once per pulse. `at_limit` is high when MAX_PULSES pulses have
// been applied. Assumes CNT_W can hold MAX_PULSES.
module byte_burn_retry #(
    parameter int unsigned MAX_PULSES = 25,
    parameter int unsigned CNT_W      = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bump,
    output logic [CNT_W-1:0] count,
    output logic             at_limit
);

    logic [CNT_W-1:0] cnt_q;

    // Count pulses applied to the current byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (bump) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expose count and budget-exhausted flag
    always_comb begin
        count    = cnt_q;
        at_limit = (cnt_q == CNT_W'(MAX_PULSES));
    end

endmodule

// File: rtl/byte_burn_fsm.sv
// Module: control state machine for the arm / pulse / margin / read /
// compare loop. The compare result and the pulse budget are inputs. It
// reports acceptance and the two ways a byte can finish. Assumes the memory
// returns read data one cycle after the read strobe.
module byte_burn_fsm
    import byte_burn_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        timer_expired,
    input  logic        match,
    input  logic        at_limit,
    output burn_state_t state,
    output logic        accept,
    output logic        finish_ok,
    output logic        finish_fail
);

    burn_state_t state_q, state_d;

    // Next-state and event decode
    always_comb begin
        state_d     = state_q;
        accept      = 1'b0;
        finish_ok   = 1'b0;
        finish_fail = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    accept  = 1'b1;
                    state_d = S_ARM;
                end
            end
            S_ARM:    state_d = S_LOAD;
            S_LOAD:   state_d = S_BURN;
            S_BURN:   if (timer_expired) state_d = S_MARGIN;
            S_MARGIN: state_d = S_READ;
            S_READ:   state_d = S_CMP;
            S_CMP: begin
                if (match) begin
                    finish_ok = 1'b1;
                    state_d   = S_IDLE;
                end else if (at_limit) begin
                    finish_fail = 1'b1;
                    state_d     = S_IDLE;
                end else begin
                    state_d = S_ARM;
                end
            end
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Present the current state
    always_comb begin
        state = state_q;
    end

endmodule

// File: rtl/byte_burn_ctrl.sv
// Module: top of the pulsed byte program sequencer. It latches an accepted
// request, drives the memory command bus from the state machine, compares
// the margin read-back with the latched byte and holds the status outputs.
// Assumes one memory command per clock and PULSE_CYC >= 2.
module byte_burn_ctrl
    import byte_burn_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned PULSE_US   = 10,
    parameter int unsigned MAX_PULSES = 25,
    parameter int unsigned ADDR_W     = 18,
    parameter int unsigned DATA_W     = 8,
    localparam int unsigned CNT_W     = $clog2(MAX_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [CNT_W-1:0]  pulses_used,
    output logic              hv_en,
    output logic              mem_we,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    localparam int unsigned PULSE_CYC = pulse_cycles(CLK_HZ, PULSE_US);
    localparam int unsigned TMR_W     = (PULSE_CYC > 2) ? $clog2(PULSE_CYC) : 1;

    burn_state_t       state;
    logic              accept, finish_ok, finish_fail;
    logic              timer_expired, match, at_limit;
    logic [CNT_W-1:0]  pulse_cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              done_q, fail_q;
    logic [CNT_W-1:0]  used_q;

    byte_burn_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .timer_expired(timer_expired),
        .match        (match),
        .at_limit     (at_limit),
        .state        (state),
        .accept       (accept),
        .finish_ok    (finish_ok),
        .finish_fail  (finish_fail)
    );

    byte_burn_timer #(
        .CNT_W   (TMR_W),
        .LOAD_VAL(PULSE_CYC - 2)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (state == S_LOAD),
        .run    (state == S_BURN),
        .expired(timer_expired)
    );

    byte_burn_retry #(
        .MAX_PULSES(MAX_PULSES),
        .CNT_W     (CNT_W)
    ) u_retry (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (accept),
        .bump    (state == S_LOAD),
        .count   (pulse_cnt),
        .at_limit(at_limit)
    );

    // Latch the request address and data on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
        end else if (accept) begin
            addr_q <= req_addr;
            data_q <= req_data;
        end
    end

    // Verify compare of margin read-back against the intended byte
    always_comb begin
        match = (state == S_CMP) && (mem_rdata == data_q);
    end

    // Status registers: completion pulse, sticky fail, pulse count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            used_q <= '0;
        end else begin
            done_q <= finish_ok | finish_fail;
            if (accept) begin
                fail_q <= 1'b0;
            end else if (finish_fail) begin
                fail_q <= 1'b1;
            end
            if (finish_ok || finish_fail) begin
                used_q <= pulse_cnt;
            end
        end
    end

    // Memory bus decode from the current state
    always_comb begin
        mem_we    = 1'b0;
        mem_rd    = 1'b0;
        mem_wdata = '0;
        unique case (state)
            S_ARM: begin
                mem_we    = 1'b1;
                mem_wdata = DATA_W'(OP_ARM);
            end
            S_LOAD: begin
                mem_we    = 1'b1;
                mem_wdata = data_q;
            end
            S_MARGIN: begin
                mem_we    = 1'b1;
                mem_wdata = DATA_W'(OP_CHECK);
            end
            S_READ:  mem_rd = 1'b1;
            default: ;
        endcase
        mem_addr = addr_q;
    end

    // Status and high-voltage outputs
    always_comb begin
        busy        = (state != S_IDLE);
        hv_en       = (state != S_IDLE);
        done        = done_q;
        fail        = fail_q;
        pulses_used = used_q;
    end

endmodule

// File: rtl/byte_burn_chk.sv
// Module: assertion checker for byte_burn_ctrl, attached with bind.
// Observes ports only.
module byte_burn_chk #(
    parameter int unsigned ADDR_W     = 18,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned CNT_W      = 5,
    parameter int unsigned MAX_PULSES = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              fail,
    input logic [CNT_W-1:0]  pulses_used,
    input logic              hv_en,
    input logic              mem_we,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata
);

    // R8: every bus strobe happens with high voltage on
    a_r8_strobe_under_hv: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_rd) |-> hv_en);

    // R4: a read strobe always directly follows the margin command
    a_r4_read_after_margin: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> $past(mem_we && mem_wdata == DATA_W'(8'hC0)));

    // R2 / R9: address is frozen while a byte is in progress
    a_r2_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_addr));

    // R5: completion is a single-cycle pulse that lands in idle
    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: completion is reported with the block idle
    a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R6: reported pulse count never exceeds the budget
    a_r6_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        pulses_used <= CNT_W'(MAX_PULSES));

    // R7: fail holds unless a request is accepted
    a_r7_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !(req_valid && !busy)) |=> fail);

endmodule

bind byte_burn_ctrl byte_burn_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .CNT_W     (CNT_W),
    .MAX_PULSES(MAX_PULSES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .busy       (busy),
    .done       (done),
    .fail       (fail),
    .pulses_used(pulses_used),
    .hv_en      (hv_en),
    .mem_we     (mem_we),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata)
);

// File: tb/test_byte_burn_ctrl.sv
// Scoreboard bench: a driver task pushes the expected result of each
// request; a monitor pops and compares on every `done`.
module test_byte_burn_ctrl;

    localparam int unsigned CLK_HZ     = 1_000_000;
    localparam int unsigned PULSE_US   = 5;
    localparam int unsigned MAX_PULSES = 25;
    localparam int unsigned ADDR_W     = 18;
    localparam int unsigned DATA_W     = 8;
    localparam int unsigned CNT_W      = $clog2(MAX_PULSES + 1);
    localparam int          PULSE_CYC  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic              busy, done, fail, hv_en, mem_we, mem_rd;
    logic [CNT_W-1:0]  pulses_used;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    typedef struct { logic exp_fail; int exp_cnt; } exp_t;
    exp_t sb[$];

    // memory model state
    int                m_need = 1;
    int                m_pulses = 0;
    logic [DATA_W-1:0] m_cell = '0;
    logic              m_armed = 1'b0;
    logic              m_margin = 1'b0;

    // bench view of the current byte
    logic [ADDR_W-1:0] cur_addr = '0;
    logic [DATA_W-1:0] cur_data = '0;
    logic              nxt_data = 1'b0;
    int                t_data = 0;
    logic              prev_margin = 1'b0;

    byte_burn_ctrl #(
        .CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US), .MAX_PULSES(MAX_PULSES),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) i_byte_burn_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .busy(busy), .done(done), .fail(fail),
        .pulses_used(pulses_used), .hv_en(hv_en), .mem_we(mem_we),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string req, input logic ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Memory model: cell holds the true byte only after enough pulses;
    // read data is the true cell only in margin mode.
    always @(posedge clk) begin
        if (req_valid && !busy) begin
            m_pulses <= 0;
            m_cell   <= ~req_data;
            m_armed  <= 1'b0;
            m_margin <= 1'b0;
        end else begin
            if (mem_we) begin
                if (m_armed) begin
                    m_pulses <= m_pulses + 1;
                    m_cell   <= (m_need != 0 && m_pulses + 1 >= m_need) ? mem_wdata : ~mem_wdata;
                    m_armed  <= 1'b0;
                end else begin
                    m_armed  <= (mem_wdata == 8'h40);
                    m_margin <= (mem_wdata == 8'hC0);
                end
            end
            if (mem_rd) begin
                mem_rdata <= m_margin ? m_cell : ~m_cell;
                m_margin  <= 1'b0;
            end
        end
    end

    // Monitor: bus protocol checks and scoreboard compare
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we || mem_rd) begin
                check("R9 address", mem_addr == cur_addr, int'(mem_addr), int'(cur_addr));
                check("R8 hv during strobe", hv_en == 1'b1, int'(hv_en), 1);
            end
            if (!busy) check("R8 hv idle", hv_en == 1'b0, int'(hv_en), 0);
            if (mem_rd) check("R4 read after margin", prev_margin, int'(prev_margin), 1);
            prev_margin = 1'b0;
            if (mem_we) begin
                if (nxt_data) begin
                    check("R3 data byte", mem_wdata == cur_data, int'(mem_wdata), int'(cur_data));
                    t_data   = cyc;
                    nxt_data = 1'b0;
                end else if (mem_wdata == 8'h40) begin
                    nxt_data = 1'b1;
                end else if (mem_wdata == 8'hC0) begin
                    check("R3 pulse length", cyc - t_data == PULSE_CYC, cyc - t_data, PULSE_CYC);
                    prev_margin = 1'b1;
                end else begin
                    check("R3 command code", 1'b0, int'(mem_wdata), 64);
                end
            end
            if (done) begin
                if (sb.size() == 0) begin
                    check("R2 unexpected result", 1'b0, 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.exp_fail ? "R6 fail flag" : "R5 fail flag",
                          fail == e.exp_fail, int'(fail), int'(e.exp_fail));
                    check(e.exp_fail ? "R6 pulse count" : "R5 pulse count",
                          int'(pulses_used) == e.exp_cnt, int'(pulses_used), e.exp_cnt);
                    check("R2 idle at done", busy == 1'b0, int'(busy), 0);
                end
            end
        end
    end

    // Driver: issue one request, record the expected result
    task automatic issue(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input int need);
        exp_t e;
        while (busy) @(negedge clk);
        m_need   = need;
        cur_addr = a;
        cur_data = d;
        nxt_data = 1'b0;
        e.exp_fail = (need == 0 || need > int'(MAX_PULSES));
        e.exp_cnt  = e.exp_fail ? int'(MAX_PULSES) : need;
        sb.push_back(e);
        req_addr  = a;
        req_data  = d;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 busy after accept", busy == 1'b1, int'(busy), 1);
        check("R7 fail cleared on accept", fail == 1'b0, int'(fail), 0);
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy == 1'b0, int'(busy), 0);
        check("R1 done", done == 1'b0, int'(done), 0);
        check("R1 fail", fail == 1'b0, int'(fail), 0);
        check("R1 hv_en", hv_en == 1'b0, int'(hv_en), 0);
        check("R1 strobes", (mem_we | mem_rd) == 1'b0, int'(mem_we | mem_rd), 0);
        check("R1 pulses_used", pulses_used == '0, int'(pulses_used), 0);

        // R5 first-pulse success, several data patterns
        issue(18'h00010, 8'hA5, 1);
        drain();
        issue(18'h3FFFF, 8'h00, 3);
        drain();
        issue(18'h01234, 8'hFF, 2);
        drain();
        // R6 boundary: success exactly on the last allowed pulse
        issue(18'h00007, 8'h5A, 25);
        drain();
        // R6 exhaustion: never verifies
        issue(18'h00100, 8'h3C, 0);
        drain();
        // R7 sticky after several idle cycles
        repeat (5) @(negedge clk);
        check("R7 fail held", fail == 1'b1, int'(fail), 1);
        check("R8 hv off after fail", hv_en == 1'b0, int'(hv_en), 0);
        issue(18'h00101, 8'h81, 2);
        drain();
        check("R7 fail stays clear", fail == 1'b0, int'(fail), 0);

        // R2 requests while busy are ignored
        issue(18'h02000, 8'h96, 4);
        req_addr  = 18'h00ABC;
        req_data  = 8'h11;
        req_valid = 1'b1;
        repeat (12) @(negedge clk);
        req_valid = 1'b0;
        drain();
        repeat (4) @(negedge clk);
        check("R2 ignored request not started", busy == 1'b0, int'(busy), 0);
        check("R2 no extra results", sb.size() == 0, sb.size(), 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule